// File: doc/BRIEF.md
# Receive Mailbox Bank with Auto-Advancing Read Pointer

This block holds a small bank of 32-bit receive mailboxes for one endpoint. The USB side deposits words straight into a mailbox chosen by number. The CPU reads them through one shared data location. A pointer register decides which mailbox that location returns. Each read of the data location moves the pointer on by one, and the pointer returns to zero after the last mailbox. Software can therefore drain the whole bank with back-to-back reads after it sets the pointer once.

The USB deposit path is a valid/ready stream. `usb_wr_ready` is low while reset is held and goes high on the first clock after reset is released. It then stays high, so a beat is taken in every cycle in which `usb_wr_valid` is high. The producer must hold a beat while ready is low, and the block never applies back-pressure after that. The CPU side has separate read and write strobes. A read and a write can therefore fall in the same cycle. Read data is registered and comes back one cycle after the read strobe, flagged by `cpu_rd_valid`.

Top module: `rx_mailbox_bank`

## Requirements
- R1: After reset the pointer is 0, every mailbox holds 0, `cpu_rd_valid` is low and `usb_wr_ready` is low. `usb_wr_ready` goes high on the first clock after reset is released.
- R2: A USB beat is accepted when `usb_wr_valid` and `usb_wr_ready` are both high. The beat stores `usb_wr_data` into the mailbox numbered `usb_wr_num`, where number k selects mailbox k.
- R3: Any CPU read (`cpu_rd_en` high) raises `cpu_rd_valid` in the next cycle, and only then. A read at address 0x24 (the data location) returns the mailbox selected by the pointer value held before the read.
- R4: After a data-location read the pointer is one higher.
- R5: A data-location read with the pointer at 7 leaves the pointer at 0.
- R6: A CPU write to address 0x20 (the pointer register) loads the pointer from `cpu_wr_data[2:0]`. A read of 0x20 returns the pointer in bits 2:0, and bits 31:3 read as zero.
- R7: A pointer-register write in the same cycle as a data-location read sets the pointer to the written value, and no advance is applied. The read still returns the mailbox picked by the old pointer.
- R8: A CPU write to the data location changes neither the pointer nor any mailbox.
- R9: A read of any address other than 0x20 or 0x24 returns 0 and does not move the pointer.
- R10: A USB beat and a data-location read that target the same mailbox in the same cycle return the mailbox's previous contents. A later read returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_wr_valid | input | 1 | USB deposit beat valid |
| usb_wr_ready | output | 1 | Deposit accepted; high from the first clock after reset release |
| usb_wr_num | input | 3 | Target mailbox number |
| usb_wr_data | input | 32 | Word to deposit |
| cpu_rd_en | input | 1 | CPU read strobe |
| cpu_rd_addr | input | 8 | CPU read byte address |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_addr | input | 8 | CPU write byte address |
| cpu_wr_data | input | 32 | CPU write data |
| cpu_rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| cpu_rd_data | output | 32 | Registered read data |

## Verification
The bank is first filled with eight distinct words. A streaming run of nine data reads then tells a correct advance and wrap apart from a stuck pointer or a missing wrap. Pointer loads are made with the upper write-data bits set, followed by a pointer read-back, which separates a correct 3-bit load from a wide or mis-sliced one. Targeted collisions cover a pointer write landing on a data read, a USB deposit landing on the mailbox being read, data-location writes, and unmapped reads. A final stretch of random mixed traffic is compared against the reference model on every clock to catch interactions between these cases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE  = 2'd0,
    RSEL_PTR   = 2'd1,
    RSEL_DATA  = 2'd2
  } rsel_e;
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int NUM_BOX = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_BOX)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [IDX_W-1:0]               wnum,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_BOX-1:0][DATA_W-1:0] boxes
);
  for (genvar g = 0; g < NUM_BOX; g++) begin : g_box
    logic hit;
    assign hit = we && (wnum == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   boxes[g] <= '0;
      else if (hit) boxes[g] <= wdata;
    end
  end
endmodule

// File: rtl/mbx_index.sv
module mbx_index #(
  parameter int NUM_BOX = 8,
  localparam int IDX_W  = $clog2(NUM_BOX),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BOX - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] stepped;
  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    stepped = (idx == LAST) ? '0 : idx + 1'b1;
    if (load)     idx_nxt = load_val;
    else if (adv) idx_nxt = stepped;
    else          idx_nxt = idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_nxt;
  end
endmodule

// File: rtl/mbx_read_mux.sv
module mbx_read_mux
  import mbx_pkg::*;
#(
  parameter int NUM_BOX = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_BOX)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_en,
  input  rsel_e                          rsel,
  input  logic [NUM_BOX-1:0][DATA_W-1:0] boxes,
  input  logic [IDX_W-1:0]               idx,
  output logic                           rvalid,
  output logic [DATA_W-1:0]              rdata
);
  logic [DATA_W-1:0] sel_word;

  always_comb begin
    unique case (rsel)
      RSEL_DATA: sel_word = boxes[idx];
      RSEL_PTR:  sel_word = DATA_W'(idx);
      default:   sel_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= sel_word;
    end
  end
endmodule

// File: rtl/rx_mailbox_bank.sv
module rx_mailbox_bank
  import mbx_pkg::*;
#(
  parameter int NUM_BOX  = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] PTR_OFS  = 8'h20,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'h24,
  localparam int IDX_W   = $clog2(NUM_BOX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_wr_valid,
  output logic              usb_wr_ready,
  input  logic [IDX_W-1:0]  usb_wr_num,
  input  logic [DATA_W-1:0] usb_wr_data,
  input  logic              cpu_rd_en,
  input  logic [ADDR_W-1:0] cpu_rd_addr,
  input  logic              cpu_wr_en,
  input  logic [ADDR_W-1:0] cpu_wr_addr,
  input  logic [DATA_W-1:0] cpu_wr_data,
  output logic              cpu_rd_valid,
  output logic [DATA_W-1:0] cpu_rd_data
);
  logic [NUM_BOX-1:0][DATA_W-1:0] boxes;
  logic [IDX_W-1:0]               cur_idx;
  rsel_e                          rsel;
  logic                           ptr_load;
  logic                           data_rd;
  logic                           usb_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) usb_wr_ready <= 1'b0;
    else        usb_wr_ready <= 1'b1;
  end

  assign usb_take = usb_wr_valid && usb_wr_ready;
  assign ptr_load = cpu_wr_en && (cpu_wr_addr == PTR_OFS);

  always_comb begin
    if (cpu_rd_addr == DATA_OFS)     rsel = RSEL_DATA;
    else if (cpu_rd_addr == PTR_OFS) rsel = RSEL_PTR;
    else                             rsel = RSEL_NONE;
  end

  assign data_rd = cpu_rd_en && (rsel == RSEL_DATA);

  mbx_store #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (usb_take),
    .wnum  (usb_wr_num),
    .wdata (usb_wr_data),
    .boxes (boxes)
  );

  mbx_index #(.NUM_BOX(NUM_BOX)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (cpu_wr_data[IDX_W-1:0]),
    .adv      (data_rd),
    .idx      (cur_idx)
  );

  mbx_read_mux #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W)) u_rmux (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (cpu_rd_en),
    .rsel   (rsel),
    .boxes  (boxes),
    .idx    (cur_idx),
    .rvalid (cpu_rd_valid),
    .rdata  (cpu_rd_data)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int NUM_BOX = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] PTR_OFS  = 8'h20,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'h24,
  localparam int IDX_W  = $clog2(NUM_BOX),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BOX - 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rd_en,
  input logic [ADDR_W-1:0] cpu_rd_addr,
  input logic              cpu_wr_en,
  input logic [ADDR_W-1:0] cpu_wr_addr,
  input logic [DATA_W-1:0] cpu_wr_data,
  input logic [IDX_W-1:0]  idx,
  input logic              cpu_rd_valid,
  input logic [DATA_W-1:0] cpu_rd_data
);
  logic d_rd, p_wr;
  assign d_rd = cpu_rd_en && (cpu_rd_addr == DATA_OFS);
  assign p_wr = cpu_wr_en && (cpu_wr_addr == PTR_OFS);

  assert_rvalid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_en |=> cpu_rd_valid);
  assert_rvalid_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd_en |=> !cpu_rd_valid);
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rd && !p_wr && idx != LAST) |=> idx == IDX_W'($past(idx) + 1'b1));
  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rd && !p_wr && idx == LAST) |=> idx == '0);
  assert_ptr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    p_wr |=> idx == $past(cpu_wr_data[IDX_W-1:0]));
  assert_ptr_hi_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_en && cpu_rd_addr == PTR_OFS) |=> cpu_rd_data[DATA_W-1:IDX_W] == '0);
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (p_wr && d_rd) |=> idx == $past(cpu_wr_data[IDX_W-1:0]));
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_wr && !d_rd) |=> $stable(idx));
endmodule

bind rx_mailbox_bank mbx_checker #(
  .NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .PTR_OFS(PTR_OFS), .DATA_OFS(DATA_OFS)
) u_mbx_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_rd_en    (cpu_rd_en),
  .cpu_rd_addr  (cpu_rd_addr),
  .cpu_wr_en    (cpu_wr_en),
  .cpu_wr_addr  (cpu_wr_addr),
  .cpu_wr_data  (cpu_wr_data),
  .idx          (cur_idx),
  .cpu_rd_valid (cpu_rd_valid),
  .cpu_rd_data  (cpu_rd_data)
);

// File: tb/test_rx_mailbox_bank.sv
`timescale 1ns/1ps
module test_rx_mailbox_bank;
  localparam logic [7:0] A_PTR  = 8'h20;
  localparam logic [7:0] A_DATA = 8'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        usb_wr_valid = 1'b0;
  logic        usb_wr_ready;
  logic [2:0]  usb_wr_num = '0;
  logic [31:0] usb_wr_data = '0;
  logic        cpu_rd_en = 1'b0;
  logic [7:0]  cpu_rd_addr = '0;
  logic        cpu_wr_en = 1'b0;
  logic [7:0]  cpu_wr_addr = '0;
  logic [31:0] cpu_wr_data = '0;
  logic        cpu_rd_valid;
  logic [31:0] cpu_rd_data;

  always #4 clk = ~clk;

  rx_mailbox_bank i_rx_mailbox_bank (.*);

  int checks = 0;
  int errors = 0;
  logic [31:0] m_box [8];
  int m_idx = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: apply the given inputs, advance the model, compare outputs.
  task automatic cyc(input string req,
                     input logic rd, input logic [7:0] ra,
                     input logic wr, input logic [7:0] wa, input logic [31:0] wd,
                     input logic uv, input logic [2:0] un, input logic [31:0] ud);
    logic        e_v;
    logic [31:0] e_d;
    cpu_rd_en = rd; cpu_rd_addr = ra;
    cpu_wr_en = wr; cpu_wr_addr = wa; cpu_wr_data = wd;
    usb_wr_valid = uv; usb_wr_num = un; usb_wr_data = ud;
    @(posedge clk);
    e_v = rd;
    if (ra == A_DATA)     e_d = m_box[m_idx];
    else if (ra == A_PTR) e_d = 32'(m_idx);
    else                  e_d = 32'h0;
    if (uv) m_box[un] = ud;
    if (wr && wa == A_PTR)        m_idx = int'(wd[2:0]);
    else if (rd && ra == A_DATA)  m_idx = (m_idx + 1) % 8;
    #2;
    check({req, " valid"}, {31'b0, cpu_rd_valid}, {31'b0, e_v});
    if (e_v) check({req, " data"}, cpu_rd_data, e_d);
    check("R2 ready", {31'b0, usb_wr_ready}, 32'd1);
    cpu_rd_en = 1'b0; cpu_wr_en = 1'b0; usb_wr_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_data(string req); cyc(req, 1, A_DATA, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd_ptr(string req);  cyc(req, 1, A_PTR, 0, 0, 0, 0, 0, 0);  endtask
  task automatic wr_ptr(string req, logic [31:0] v); cyc(req, 0, 0, 1, A_PTR, v, 0, 0, 0); endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    foreach (m_box[i]) m_box[i] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 valid in reset", {31'b0, cpu_rd_valid}, 32'd0);
    check("R1 ready in reset", {31'b0, usb_wr_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_ptr("R1 pointer after reset");
    // R1: every mailbox reads zero; wraps back to 0
    for (int i = 0; i < 8; i++) rd_data("R1 mailbox zero");
    // R2: fill with distinct words
    for (int i = 0; i < 8; i++)
      cyc("R2 deposit", 0, 0, 0, 0, 0, 1, 3'(i), 32'hA5000000 + 32'(i * 17));
    // R3 R4 R5: stream through and wrap
    for (int i = 0; i < 9; i++) rd_data("R3 R4 R5 stream");
    rd_ptr("R4 pointer after stream");
    // R6: load with upper bits set
    wr_ptr("R6 load", 32'hFFFF_FFFD);
    rd_ptr("R6 readback");
    for (int i = 0; i < 4; i++) rd_data("R5 wrap from 5");
    rd_ptr("R5 pointer after wrap");
    // R7: load coincides with data read
    cyc("R7 load wins", 1, A_DATA, 1, A_PTR, 32'h6, 0, 0, 0);
    rd_ptr("R7 pointer");
    rd_data("R7 read at loaded pointer");
    // R8: data-location write has no effect
    cyc("R8 data write", 0, 0, 1, A_DATA, 32'hDEAD_BEEF, 0, 0, 0);
    rd_ptr("R8 pointer unchanged");
    wr_ptr("R8 reposition", 32'h0);
    for (int i = 0; i < 8; i++) rd_data("R8 mailboxes unchanged");
    // R9: unmapped read
    cyc("R9 unmapped", 1, 8'h28, 0, 0, 0, 0, 0, 0);
    cyc("R9 unmapped", 1, 8'h00, 0, 0, 0, 0, 0, 0);
    rd_ptr("R9 pointer unchanged");
    // R10: deposit and read same mailbox
    wr_ptr("R10 set", 32'h3);
    cyc("R10 collide old", 1, A_DATA, 0, 0, 0, 1, 3'd3, 32'h1234_5678);
    wr_ptr("R10 set", 32'h3);
    rd_data("R10 new word");
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      logic [7:0]  ra, wa;
      r = $urandom;
      ra = (r[1:0] == 2'd0) ? A_PTR : (r[1:0] == 2'd3) ? 8'h2C : A_DATA;
      wa = r[4] ? A_PTR : A_DATA;
      cyc("R3 R4 R7 R10 random", r[2], ra, r[3] & r[5], wa, $urandom, r[6], r[9:7], $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule